// File: doc/BRIEF.md
# Recency-plus-Cost Replacement Victim Selector

This block picks which way of a 16-way set-associative cache is evicted on a miss. For every way of every set it keeps a position in a recency stack and a 3-bit quantized miss cost. Position 0 is the least recently used way and position 15 the most recently used. The cost is written when the line is filled. Every hit or fill moves the accessed way to the most recently used position.

On a miss request the block looks at the addressed set and returns the way to evict, one cycle later. Under the plain policy this is the least recently used way. Under the weighted policy it is the way with the smallest sum of recency position and cost scaled by a power-of-two weight. With the weighting, a line whose earlier miss was expensive tends to stay in the cache even when it is older. Empty ways are always used before any occupied way. Tags and data live elsewhere. The surrounding cache controller supplies hit and fill notifications and miss requests.

Top module: `victim_select`

## Requirements
- R1: After reset every way of every set is invalid, `victim_valid` is 0, and way w of each set holds recency position w.
- R2: `victim_valid` is 1 in exactly the cycle after a cycle with `miss_req` high. `victim_way` then holds the choice made for `miss_set`, using the state as it was in the request cycle, and changes only after a miss request.
- R3: If the addressed set has any invalid way, the victim is the lowest-numbered invalid way, whatever `lin_sel` is.
- R4: With `lin_sel` = 0 and all ways valid, the victim is the way at recency position 0.
- R5: With `lin_sel` = 1 and all ways valid, the victim is the way with the smallest score = position + cost × 2^COST_SHIFT. The default COST_SHIFT is 2, so the weight is 4.
- R6: When several ways share the smallest score, the lowest-numbered way is chosen.
- R7: When `upd_en` is high, way `upd_way` of set `upd_set` moves to position 15. Every way of that set that held a higher position drops by one, and all other positions stay the same.
- R8: An update with `upd_fill` = 1 marks the way valid and stores `upd_cost`. An update with `upd_fill` = 0 (a hit) changes neither the valid bit nor the cost.
- R9: Updates and misses touch only the addressed set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Access notification (hit or fill) |
| upd_fill | input | 1 | 1 = fill (writes cost, sets valid), 0 = hit |
| upd_set | input | 3 | Set of the access |
| upd_way | input | 4 | Way of the access |
| upd_cost | input | 3 | Quantized miss cost recorded on fill |
| miss_req | input | 1 | Request a victim for `miss_set` |
| miss_set | input | 3 | Set that missed |
| lin_sel | input | 1 | 0 = least recently used, 1 = recency plus weighted cost |
| victim_valid | output | 1 | Victim result present |
| victim_way | output | 4 | Way to evict |

## Verification
Some behaviours are checked by assertions on every cycle:
- Each set keeps exactly one way at the top position.
- An accessed way reaches the top position.
- A fill leaves the way valid, holding the cost that was written.
- A returned victim is invalid whenever the set was not full at the time of the request.
- Under the plain policy, a victim taken from a full set is at position 0.
- The victim output holds still between requests.

The exact weighted scores, tie-breaking toward the low way, the effect of a hit on costs and the independence of the sets are shown only by the bench's scenarios. In those scenarios the orderings and costs are built up across many accesses and the expected victims are worked out by hand.

// File: rtl/victim_select.sv
module victim_select #(
  parameter int WAYS       = 16,
  parameter int SETS       = 8,
  parameter int COST_W     = 3,
  parameter int COST_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  logic                      upd_fill,
  input  logic [$clog2(SETS)-1:0]   upd_set,
  input  logic [$clog2(WAYS)-1:0]   upd_way,
  input  logic [COST_W-1:0]         upd_cost,
  input  logic                      miss_req,
  input  logic [$clog2(SETS)-1:0]   miss_set,
  input  logic                      lin_sel,
  output logic                      victim_valid,
  output logic [$clog2(WAYS)-1:0]   victim_way
);
  localparam int RANK_W  = $clog2(WAYS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int SET_W   = $clog2(SETS);
  localparam int SCORE_W = RANK_W + COST_W + COST_SHIFT;
  localparam logic [RANK_W-1:0] TOP = RANK_W'(WAYS - 1);

  logic [RANK_W-1:0] rank_q  [SETS][WAYS];
  logic [COST_W-1:0] cost_q  [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];

  logic [RANK_W-1:0] upd_rank;
  assign upd_rank = rank_q[upd_set][upd_way];

  logic             inv_any;
  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] best_way;
  logic [SCORE_W-1:0] best_score;
  logic [SCORE_W-1:0] score;

  always_comb begin
    inv_any = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[miss_set][w]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    best_score = '1;
    best_way   = '0;
    score      = '0;
    for (int w = 0; w < WAYS; w++) begin
      score = SCORE_W'(rank_q[miss_set][w]);
      if (lin_sel)
        score = score + (SCORE_W'(cost_q[miss_set][w]) << COST_SHIFT);
      if (score < best_score) begin
        best_score = score;
        best_way   = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          rank_q[s][w] <= RANK_W'(w);
          cost_q[s][w] <= '0;
        end
      end
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      if (upd_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way)
            rank_q[upd_set][w] <= TOP;
          else if (rank_q[upd_set][w] > upd_rank)
            rank_q[upd_set][w] <= rank_q[upd_set][w] - 1'b1;
        end
        if (upd_fill) begin
          valid_q[upd_set][upd_way] <= 1'b1;
          cost_q[upd_set][upd_way]  <= upd_cost;
        end
      end
      victim_valid <= miss_req;
      if (miss_req)
        victim_way <= inv_any ? inv_way : best_way;
    end
  end

  logic [SETS-1:0] top_once;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      int n;
      n = 0;
      for (int w = 0; w < WAYS; w++)
        if (rank_q[s][w] == TOP) n++;
      top_once[s] = (n == 1);
    end
  end

  logic                     last_upd, last_fill, snap_lin;
  logic [SET_W-1:0]         last_set;
  logic [WAY_W-1:0]         last_way;
  logic [COST_W-1:0]        last_cost;
  logic [WAYS-1:0]          snap_valid;
  logic [WAYS-1:0][RANK_W-1:0] snap_rank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_upd   <= 1'b0;
      last_fill  <= 1'b0;
      last_set   <= '0;
      last_way   <= '0;
      last_cost  <= '0;
      snap_lin   <= 1'b0;
      snap_valid <= '1;
      snap_rank  <= '0;
    end else begin
      last_upd  <= upd_en;
      last_fill <= upd_en && upd_fill;
      last_set  <= upd_set;
      last_way  <= upd_way;
      last_cost <= upd_cost;
      if (miss_req) begin
        snap_lin   <= lin_sel;
        snap_valid <= valid_q[miss_set];
        for (int w = 0; w < WAYS; w++)
          snap_rank[w] <= rank_q[miss_set][w];
      end
    end
  end

  // R7
  top_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) &top_once);

  // R7
  to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_upd |-> rank_q[last_set][last_way] == TOP);

  // R8
  fill_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fill |-> (valid_q[last_set][last_way] && cost_q[last_set][last_way] == last_cost));

  // R3
  empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !(&snap_valid)) |-> !snap_valid[victim_way]);

  // R4
  lru_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && (&snap_valid) && !snap_lin) |-> snap_rank[victim_way] == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req |=> $stable(victim_way));
endmodule

// File: tb/sim_victim_select.sv
`timescale 1ns/1ps
module sim_victim_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_en = 1'b0, upd_fill = 1'b0, miss_req = 1'b0, lin_sel = 1'b0;
  logic [2:0] upd_set = '0, miss_set = '0, upd_cost = '0;
  logic [3:0] upd_way = '0;
  logic victim_valid;
  logic [3:0] victim_way;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  victim_select u0 (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_fill(upd_fill), .upd_set(upd_set),
    .upd_way(upd_way), .upd_cost(upd_cost),
    .miss_req(miss_req), .miss_set(miss_set), .lin_sel(lin_sel),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  // nibbles: op (0 miss, 1 hit, 2 fill), way, cost, lin, expected victim; set 1
  localparam int NV = 12;
  localparam bit [19:0] VEC [NV] = '{
    20'h00000, 20'h00014, 20'h14000, 20'h00019,
    20'h00000, 20'h10000, 20'h00001, 20'h19000,
    20'h00014, 20'h24700, 20'h00019, 20'h00001
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input int s, input int w, input bit fill, input int c);
    @(negedge clk);
    upd_en = 1'b1; upd_fill = fill; upd_set = 3'(s); upd_way = 4'(w); upd_cost = 3'(c);
    @(negedge clk);
    upd_en = 1'b0; upd_fill = 1'b0;
  endtask

  task automatic miss(input int s, input bit lin, input int exp, input string tag);
    @(negedge clk);
    miss_req = 1'b1; miss_set = 3'(s); lin_sel = lin;
    @(negedge clk);
    miss_req = 1'b0;
    check(victim_valid == 1'b1, "R2 valid", int'(victim_valid), 1);
    check(victim_way == 4'(exp), tag, int'(victim_way), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(victim_valid == 1'b0, "R1 valid low", int'(victim_valid), 0);
    miss(0, 1'b1, 0, "R1 empty set gives way 0");
    @(negedge clk);
    check(victim_valid == 1'b0, "R2 single cycle", int'(victim_valid), 0);

    // R8: a hit on an empty way leaves it invalid
    access(5, 0, 1'b0, 0);
    miss(5, 1'b0, 0, "R8 hit keeps way invalid");

    // fill set 1 in way order; ways 4 and 9 cheap, others cost 7
    for (int w = 0; w < 16; w++)
      access(1, w, 1'b1, (w == 4 || w == 9) ? 0 : 7);

    for (int i = 0; i < NV; i++) begin
      int op, way, cost, lin, exp;
      op   = int'(VEC[i][19:16]);
      way  = int'(VEC[i][15:12]);
      cost = int'(VEC[i][11:8]);
      lin  = int'(VEC[i][7:4]);
      exp  = int'(VEC[i][3:0]);
      if (op == 0) miss(1, lin[0], exp, lin[0] ? "R5 weighted victim" : "R4 lru victim");
      else access(1, way, op == 2, cost); // R7 reorder, R8 fill cost
    end

    // R6 tie: way 3 (pos 3, cost 1) and way 7 (pos 7, cost 0) both score 7
    for (int w = 0; w < 16; w++)
      access(2, w, 1'b1, (w == 3) ? 1 : ((w == 7 || w == 11) ? 0 : 7));
    miss(2, 1'b1, 3, "R6 tie lowest way");
    miss(2, 1'b0, 0, "R4 lru after ordered fill");

    // R3 partially filled set: empty way wins over cheap valid ways
    access(3, 0, 1'b1, 0);
    access(3, 1, 1'b1, 0);
    access(3, 2, 1'b1, 0);
    miss(3, 1'b1, 3, "R3 empty first weighted");
    miss(3, 1'b0, 3, "R3 empty first lru");

    // R9 other sets untouched
    miss(0, 1'b0, 0, "R9 set 0 still empty");
    miss(5, 1'b1, 0, "R9 set 5 still empty");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule